// File: doc/BRIEF.md
# Fine-Adjust Precision Time Counter

This block keeps a running time of day as a seconds field and a nanoseconds field, for use as the clock behind packet time stamps. It does not tick once per system clock. A 32-bit phase accumulator adds a programmable addend on every system clock, and each carry out of that accumulator moves the nanoseconds field forward by a programmable sub-second increment. The addend is roughly (tick rate x 2^32) / system clock rate, for example a 50 MHz tick target with an increment of 20 ns. Changing the addend by one trims the rate of the time by a fraction of a part per billion.

Software reaches the block through a single write port. Through it, software sets the time outright, steps the time forward or backward by a signed offset, stages a new addend and commits it, and arms a target time. When the running time reaches the target, the block raises a one-cycle alarm pulse and a sticky target-reached flag. The flag drives an interrupt line that can be masked. The live time and a busy bit for each self-clearing command are visible at all times.

Register map (3-bit address, 32-bit data): 0 control, 1 offset/load seconds, 2 offset/load nanoseconds (bit 31 = subtract), 3 staged addend, 4 target seconds, 5 target nanoseconds, 6 status (bit 0 = target reached, write 1 to clear), 7 sub-second increment (bits 7:0). Control bits: 0 run, 1 load time, 2 step time, 3 commit addend, 4 alarm enable, 5 interrupt mask.

Top module: `fine_time_counter`

## Requirements
- R1: While run (control bit 0) is 1, the accumulator adds the committed addend each clock. The nanoseconds field grows by the increment (address 7) on the same edge on which that add carries out of bit 31.
- R2: A write to the staged addend (address 3) does not change the rate. The committed addend takes the staged value only on the edge after a control write with bit 3 set.
- R3: Nanoseconds stay in 0..999,999,999. An advance that reaches 1,000,000,000 wraps and adds one to the seconds field.
- R4: A control write with bit 1 set replaces the time with the values at addresses 1 and 2 on the next edge. This takes priority over a step and a tick in the same cycle.
- R5: A control write with bit 2 set and bit 31 of address 2 clear adds the seconds and nanoseconds offset to the time on the next edge, carrying from nanoseconds into seconds.
- R6: With bit 31 of address 2 set, the step subtracts the offset instead, borrowing one second when the nanoseconds would go negative.
- R7: While run is 0, neither the accumulator nor the time changes except through the load and step commands.
- R8: Each command bit (load=busy[0], step=busy[1], commit=busy[2]) reads busy for exactly the one cycle after its control write, then clears by itself.
- R9: Writing a target register, or a control write with bit 4 set, arms the alarm. The first edge on which the block is armed, running, alarm-enabled and the time is at or past the target sets the target-reached flag, pulses alarmPulse for one cycle and disarms.
- R10: The target-reached flag stays set until status bit 0 is written with 1, and it does not set again without a new arm.
- R11: alarmIrq is the flag gated by control bit 5 (mask). With the mask set, the flag still sets but the interrupt stays low.
- R12: With alarm enable (control bit 4) at 0, passing the target sets neither the flag nor the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| timeSec | output | 32 | Running seconds |
| timeNs | output | 30 | Running nanoseconds |
| cmdBusy | output | 3 | Pending load, step and commit commands |
| targetReached | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Masked alarm interrupt |
| alarmPulse | output | 1 | One-cycle pulse when the target is reached |

## Verification
The rate path is tried with a half-scale addend, which carries on every second clock. That pattern separates an off-by-one in the carry edge from a correct count, and a staged-but-uncommitted addend from a committed one. The time arithmetic is tried with a tick that crosses the one-second boundary, a forward step with a nanosecond carry, a backward step with a borrow, and a backward step without one. These cases tell the carry and borrow paths apart. The alarm is tried with the interrupt mask clear, with it set, and with alarm enable clear, against a target that the running time crosses. After the flag is cleared, the bench checks that the alarm does not fire again.

// File: rtl/fine_time_pkg.sv
package fine_time_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int ACC_W  = 32;
  localparam int INC_W  = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int BUSY_W = 3;
  localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_UPDSEC = 3'd1;
  localparam logic [ADDR_W-1:0] A_UPDNS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ADDEND = 3'd3;
  localparam logic [ADDR_W-1:0] A_TGTSEC = 3'd4;
  localparam logic [ADDR_W-1:0] A_TGTNS  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] A_SUBINC = 3'd7;

  localparam int B_RUN  = 0;
  localparam int B_INIT = 1;
  localparam int B_STEP = 2;
  localparam int B_COMMIT = 3;
  localparam int B_TRIG = 4;
  localparam int B_MASK = 5;

  typedef struct packed {
    logic run;
    logic init;
    logic step;
    logic commit;
  } cmd_t;
endpackage

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import fine_time_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic [SEC_W-1:0]  updSec,
  input  logic [DATA_W-1:0] updNs,
  input  logic [ACC_W-1:0]  addendStage,
  input  logic [INC_W-1:0]  subInc,
  output logic [SEC_W-1:0]  timeSec,
  output logic [NS_W-1:0]   timeNs
);
  logic [ACC_W-1:0] accQ, addActQ;
  logic [ACC_W:0]   accSum;
  logic             tick;
  logic [SEC_W-1:0] secQ, secD;
  logic [NS_W-1:0]  nsQ, nsD, offNs;
  logic [NS_W:0]    nsTick, nsAdd, nsDiff, limit;

  always_comb begin
    accSum = {1'b0, accQ} + {1'b0, addActQ};
    tick   = cmd.run & accSum[ACC_W];
    offNs  = updNs[NS_W-1:0];
    limit  = {1'b0, NS_PER_SEC};
    nsTick = {1'b0, nsQ} + (NS_W+1)'(subInc);
    nsAdd  = {1'b0, nsQ} + {1'b0, offNs};
    nsDiff = {1'b0, nsQ} - {1'b0, offNs};
    secD   = secQ;
    nsD    = nsQ;
    if (cmd.init) begin
      secD = updSec;
      nsD  = offNs;
    end else if (cmd.step) begin
      if (updNs[DATA_W-1]) begin
        if (nsDiff[NS_W]) begin
          nsD  = NS_W'(nsDiff + limit);
          secD = secQ - updSec - SEC_W'(1);
        end else begin
          nsD  = nsDiff[NS_W-1:0];
          secD = secQ - updSec;
        end
      end else if (nsAdd >= limit) begin
        nsD  = NS_W'(nsAdd - limit);
        secD = secQ + updSec + SEC_W'(1);
      end else begin
        nsD  = nsAdd[NS_W-1:0];
        secD = secQ + updSec;
      end
    end else if (tick) begin
      if (nsTick >= limit) begin
        nsD  = NS_W'(nsTick - limit);
        secD = secQ + SEC_W'(1);
      end else begin
        nsD = nsTick[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      addActQ <= '0;
      secQ    <= '0;
      nsQ     <= '0;
    end else begin
      if (cmd.run) accQ <= accSum[ACC_W-1:0];
      if (cmd.commit) addActQ <= addendStage;
      secQ <= secD;
      nsQ  <= nsD;
    end
  end

  assign timeSec = secQ;
  assign timeNs  = nsQ;

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeNs < NS_PER_SEC);

  // R7
  halt_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.init && !cmd.step) |=> ($stable(timeSec) && $stable(timeNs) && $stable(accQ)));
endmodule

// File: rtl/ftc_ctrl.sv
module ftc_ctrl
  import fine_time_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEC_W-1:0]  timeSec,
  input  logic [NS_W-1:0]   timeNs,
  output cmd_t              cmd,
  output logic [SEC_W-1:0]  updSec,
  output logic [DATA_W-1:0] updNs,
  output logic [ACC_W-1:0]  addendStage,
  output logic [INC_W-1:0]  subInc,
  output logic [BUSY_W-1:0] cmdBusy,
  output logic              targetReached,
  output logic              alarmIrq,
  output logic              alarmPulse
);
  logic runQ, trigQ, maskQ, armedQ, reachedQ, pulseQ;
  logic pendInitQ, pendStepQ, pendCommitQ;
  logic [SEC_W-1:0] tgtSecQ;
  logic [NS_W-1:0]  tgtNsQ;
  logic wrCtrl, armNow, atOrAfter, fire;

  always_comb begin
    wrCtrl    = wrEn && (wrAddr == A_CTRL);
    armNow    = (wrEn && (wrAddr == A_TGTSEC || wrAddr == A_TGTNS)) ||
                (wrCtrl && wrData[B_TRIG]);
    atOrAfter = (timeSec > tgtSecQ) || ((timeSec == tgtSecQ) && (timeNs >= tgtNsQ));
    fire      = armedQ && trigQ && runQ && atOrAfter;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0; trigQ <= 1'b0; maskQ <= 1'b0;
      pendInitQ <= 1'b0; pendStepQ <= 1'b0; pendCommitQ <= 1'b0;
      updSec <= '0; updNs <= '0; addendStage <= '0; subInc <= '0;
      tgtSecQ <= '0; tgtNsQ <= '0;
      armedQ <= 1'b0; reachedQ <= 1'b0; pulseQ <= 1'b0;
    end else begin
      pendInitQ   <= wrCtrl && wrData[B_INIT];
      pendStepQ   <= wrCtrl && wrData[B_STEP];
      pendCommitQ <= wrCtrl && wrData[B_COMMIT];
      if (wrCtrl) begin
        runQ  <= wrData[B_RUN];
        trigQ <= wrData[B_TRIG];
        maskQ <= wrData[B_MASK];
      end
      if (wrEn) begin
        case (wrAddr)
          A_UPDSEC: updSec      <= wrData[SEC_W-1:0];
          A_UPDNS:  updNs       <= wrData;
          A_ADDEND: addendStage <= wrData[ACC_W-1:0];
          A_TGTSEC: tgtSecQ     <= wrData[SEC_W-1:0];
          A_TGTNS:  tgtNsQ      <= wrData[NS_W-1:0];
          A_SUBINC: subInc      <= wrData[INC_W-1:0];
          default: ;
        endcase
      end
      if (armNow)    armedQ <= 1'b1;
      else if (fire) armedQ <= 1'b0;
      if (fire) reachedQ <= 1'b1;
      else if (wrEn && wrAddr == A_STATUS && wrData[0]) reachedQ <= 1'b0;
      pulseQ <= fire;
    end
  end

  always_comb begin
    cmd.run    = runQ;
    cmd.init   = pendInitQ;
    cmd.step   = pendStepQ;
    cmd.commit = pendCommitQ;
    cmdBusy    = {pendCommitQ, pendStepQ, pendInitQ};
    targetReached = reachedQ;
    alarmIrq   = reachedQ && !maskQ;
    alarmPulse = pulseQ;
  end

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendInitQ && !(wrCtrl && wrData[B_INIT])) |=> !pendInitQ);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> targetReached);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmPulse && !armNow) |=> !alarmPulse);

  // R12
  pulse_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmPulse) |-> $past(trigQ));
endmodule

// File: rtl/fine_time_counter.sv
module fine_time_counter
  import fine_time_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  timeSec,
  output logic [NS_W-1:0]   timeNs,
  output logic [BUSY_W-1:0] cmdBusy,
  output logic              targetReached,
  output logic              alarmIrq,
  output logic              alarmPulse
);
  cmd_t              cmd;
  logic [SEC_W-1:0]  updSec;
  logic [DATA_W-1:0] updNs;
  logic [ACC_W-1:0]  addendStage;
  logic [INC_W-1:0]  subInc;

  ftc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeSec(timeSec), .timeNs(timeNs), .cmd(cmd), .updSec(updSec),
    .updNs(updNs), .addendStage(addendStage), .subInc(subInc),
    .cmdBusy(cmdBusy), .targetReached(targetReached), .alarmIrq(alarmIrq),
    .alarmPulse(alarmPulse)
  );

  ftc_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .updSec(updSec), .updNs(updNs),
    .addendStage(addendStage), .subInc(subInc),
    .timeSec(timeSec), .timeNs(timeNs)
  );
endmodule

// File: tb/sim_fine_time_counter.sv
module sim_fine_time_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] timeSec;
  logic [29:0] timeNs;
  logic [2:0]  cmdBusy;
  logic        targetReached, alarmIrq, alarmPulse;
  int nChecks = 0;
  int nFails = 0;

  localparam logic [31:0] C_RUN = 32'h01, C_INIT = 32'h02, C_STEP = 32'h04,
                          C_COMMIT = 32'h08, C_TRIG = 32'h10, C_MASK = 32'h20;

  always #10 clk = ~clk;

  fine_time_counter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeSec(timeSec), .timeNs(timeNs), .cmdBusy(cmdBusy),
    .targetReached(targetReached), .alarmIrq(alarmIrq), .alarmPulse(alarmPulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(timeSec == 0 && timeNs == 0, "reset time", timeSec, 0);
    check(cmdBusy == 0 && !targetReached && !alarmIrq && !alarmPulse, "reset flags", cmdBusy, 0);
  endtask

  task automatic testRate();
    doReset();
    wr(3'd7, 32'd20);
    wr(3'd3, 32'h8000_0000);
    wr(3'd0, C_RUN);
    repeat (40) @(negedge clk);
    check(timeNs == 0, "R2 staged addend ignored", timeNs, 0);
    wr(3'd0, C_RUN | C_COMMIT);
    check(cmdBusy == 3'b100, "R8 commit busy", cmdBusy, 4);
    @(negedge clk);
    check(cmdBusy == 3'b000, "R8 commit self-clear", cmdBusy, 0);
    repeat (100) @(negedge clk);
    check(timeNs == 1000, "R1 carry-driven rate", timeNs, 1000);
  endtask

  task automatic testRollover();
    doReset();
    wr(3'd7, 32'd20);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd999_999_990);
    wr(3'd3, 32'h8000_0000);
    wr(3'd0, C_RUN | C_INIT | C_COMMIT);
    check(cmdBusy == 3'b101, "R8 init busy", cmdBusy, 5);
    @(negedge clk);
    check(timeSec == 5 && timeNs == 999_999_990, "R4 load time", timeNs, 999_999_990);
    repeat (2) @(negedge clk);
    check(timeSec == 6, "R3 seconds carry", timeSec, 6);
    check(timeNs == 10, "R3 ns wrap", timeNs, 10);
  endtask

  task automatic testStep();
    doReset();
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd900_000_000);
    wr(3'd0, C_INIT);
    @(negedge clk);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd200_000_000);
    wr(3'd0, C_STEP);
    check(cmdBusy == 3'b010, "R8 step busy", cmdBusy, 2);
    @(negedge clk);
    check(timeSec == 13 && timeNs == 100_000_000, "R5 forward step carry", timeNs, 100_000_000);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'h8000_0000 | 32'd300_000_000);
    wr(3'd0, C_STEP);
    @(negedge clk);
    check(timeSec == 9, "R6 borrow seconds", timeSec, 9);
    check(timeNs == 800_000_000, "R6 borrow ns", timeNs, 800_000_000);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'h8000_0000 | 32'd500_000_000);
    wr(3'd0, C_STEP);
    @(negedge clk);
    check(timeSec == 8 && timeNs == 300_000_000, "R6 subtract no borrow", timeNs, 300_000_000);
    wr(3'd7, 32'd50);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, C_COMMIT);
    repeat (20) @(negedge clk);
    check(timeSec == 8 && timeNs == 300_000_000, "R7 halted while run low", timeNs, 300_000_000);
  endtask

  task automatic alarmSetup(input logic [31:0] ctrl);
    doReset();
    wr(3'd7, 32'd20);
    wr(3'd3, 32'h8000_0000);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd200);
    wr(3'd0, ctrl);
  endtask

  task automatic testAlarm();
    bit seen = 0;
    alarmSetup(C_RUN | C_COMMIT | C_TRIG);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (alarmPulse) begin seen = 1; break; end
    end
    check(seen, "R9 alarm pulse seen", seen, 1);
    check(timeNs == 200, "R9 pulse at target", timeNs, 200);
    check(targetReached && alarmIrq, "R11 irq unmasked", alarmIrq, 1);
    @(negedge clk);
    check(!alarmPulse, "R9 single pulse", alarmPulse, 0);
    check(targetReached, "R10 flag sticky", targetReached, 1);
    wr(3'd6, 32'd1);
    check(!targetReached && !alarmIrq, "R10 write-one clear", targetReached, 0);
    repeat (20) @(negedge clk);
    check(!targetReached, "R10 no refire without arm", targetReached, 0);
  endtask

  task automatic testMask();
    alarmSetup(C_RUN | C_COMMIT | C_TRIG | C_MASK);
    repeat (40) @(negedge clk);
    check(targetReached, "R11 flag sets while masked", targetReached, 1);
    check(!alarmIrq, "R11 irq masked", alarmIrq, 0);
  endtask

  task automatic testNoTrig();
    alarmSetup(C_RUN | C_COMMIT);
    repeat (40) @(negedge clk);
    check(timeNs >= 200, "R12 time passed target", timeNs, 200);
    check(!targetReached && !alarmPulse, "R12 no alarm without enable", targetReached, 0);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testRate();
    testRollover();
    testStep();
    testAlarm();
    testMask();
    testNoTrig();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule